// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle it may accept one operation, chosen by a 4-bit select. The operation acts on the accumulator value, a second operand from memory or a register, and the current carry flag. One clock edge later it presents the result and the four condition flags: carry, zero, negative and overflow.

Each output comes with its own update enable. A result-write enable tells the surrounding core whether to store the result. A separate enable for each flag tells it which flags to overwrite. Compare and bit test update flags without producing a result to store. Increment and decrement leave carry and overflow alone. Operand fetch, register storage and decimal arithmetic belong to the surrounding core.

The block is built as a decoder that turns the select code into a packed strobe bundle, and a datapath that acts on that bundle. All outputs are registered. A cycle with no valid operation raises no enable and holds the result register.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted and after its release, until the first valid operation, every output (result, flags and all enables) is 0.
- R2: Code 0 (add with carry) gives result = acc + operand + carry mod 256 and carry = the bit-8 carry-out. Code 1 (subtract with borrow) adds the one's complement of the operand plus the carry, so carry=1 means no borrow. Both codes write the result and update all four flags.
- R3: For codes 0 and 1, overflow is 1 when the two adder inputs share a sign bit that differs from bit 7 of the result.
- R4: Codes 2 (AND), 3 (OR) and 4 (XOR) write the bitwise result. They update zero (result is 0) and negative (result bit 7), and update neither carry nor overflow.
- R5: Code 5 shifts the accumulator left and code 6 shifts it right. A 0 enters the vacated bit, and the bit shifted out goes to carry. Result, carry, zero and negative are updated, and overflow is not.
- R6: Code 7 rotates the accumulator left through carry and code 8 rotates it right through carry. The incoming carry fills the vacated bit, and the bit shifted out becomes the new carry. The flag updates match those of R5.
- R7: Code 9 (increment) and code 10 (decrement) act on the operand and wrap modulo 256. They write the result, set zero and negative from that result, and update neither carry nor overflow.
- R8: Code 11 (compare) forms acc - operand. It sets carry when acc >= operand (unsigned), and sets zero and negative from the 8-bit difference. It does not write the result (the result output keeps its old value) and does not update overflow.
- R9: Code 12 (bit test) sets zero when acc AND operand is 0, negative from operand bit 7 and overflow from operand bit 6. It updates neither result nor carry.
- R10: Code 13 (load) passes the operand to the result, writes it, and updates zero and negative only.
- R11: Outputs appear one clock edge after the operation is presented. A cycle with the valid input low raises no enable on the next edge and leaves the result output unchanged.
- R12: Codes 14 and 15 are unused. With valid high they raise no enable and leave the result output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opSel | input | 4 | Operation code |
| accIn | input | DATA_W | Accumulator operand |
| operandIn | input | DATA_W | Memory or register operand |
| carryIn | input | 1 | Current carry flag |
| resultOut | output | DATA_W | Registered result |
| resultWrEn | output | 1 | Result should be stored |
| carryOut | output | 1 | Next carry flag |
| carryUpd | output | 1 | Carry flag should be updated |
| zeroOut | output | 1 | Next zero flag |
| zeroUpd | output | 1 | Zero flag should be updated |
| negOut | output | 1 | Next negative flag |
| negUpd | output | 1 | Negative flag should be updated |
| ovfOut | output | 1 | Next overflow flag |
| ovfUpd | output | 1 | Overflow flag should be updated |

## Verification
The bench builds the block only at the default DATA_W of 8. That is the width at which the expected values are written: bit 7 as sign, bit 6 as the bit-test overflow source, and 256 as the wrap modulus. At this width the adder carry-out at 0xFF + 1 can be reached, as can the signed overflow at 0x50 + 0x50, the increment wrap from 0xFF to 0x00 and the decrement wrap from 0x00 to 0xFF. The held-result checks after compare, bit test, idle cycles and unused codes confirm, at the ports, that those operations leave the stored value untouched.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 4;

  // Operation codes; values are part of the interface.
  typedef enum logic [OP_W-1:0] {
    OP_ADD_C = 4'd0,
    OP_SUB_B = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_SHL   = 4'd5,
    OP_SHR   = 4'd6,
    OP_ROL   = 4'd7,
    OP_ROR   = 4'd8,
    OP_INC   = 4'd9,
    OP_DEC   = 4'd10,
    OP_CMP   = 4'd11,
    OP_BIT   = 4'd12,
    OP_LOAD  = 4'd13
  } aluOp_e;

  // Which unit drives the result bus.
  typedef enum logic [2:0] {
    UNIT_PASS,
    UNIT_ADD,
    UNIT_AND,
    UNIT_OR,
    UNIT_XOR,
    UNIT_SHL,
    UNIT_SHR
  } unitSel_e;

  // Second adder input.
  typedef enum logic [1:0] {
    B_OPERAND,
    B_INVERTED,
    B_ZERO,
    B_ONES
  } addB_e;

  // Adder carry-in source.
  typedef enum logic [1:0] {
    CIN_FLAG,
    CIN_ONE,
    CIN_ZERO
  } cinSel_e;

  // Strobe bundle from control to datapath.
  typedef struct packed {
    unitSel_e unit;
    logic     addFromOperand;  // adder A side takes the operand (inc/dec)
    addB_e    addB;
    cinSel_e  cin;
    logic     rotate;          // shifter fills vacated bit from carry
    logic     bitTest;         // negative/overflow come from the raw operand
    logic     wrResult;
    logic     updCarry;
    logic     updZero;
    logic     updNeg;
    logic     updOvf;
  } ctrlStrobes_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opSel,
  output ctrlStrobes_t    strobes
);

  always_comb begin
    strobes      = '0;
    strobes.unit = UNIT_PASS;
    strobes.addB = B_OPERAND;
    strobes.cin  = CIN_FLAG;
    if (opValid) begin
      case (opSel)
        OP_ADD_C, OP_SUB_B: begin
          strobes.unit     = UNIT_ADD;
          strobes.addB     = (opSel == OP_SUB_B) ? B_INVERTED : B_OPERAND;
          strobes.wrResult = 1'b1;
          strobes.updCarry = 1'b1;
          strobes.updZero  = 1'b1;
          strobes.updNeg   = 1'b1;
          strobes.updOvf   = 1'b1;
        end
        OP_AND, OP_OR, OP_XOR: begin
          strobes.unit     = (opSel == OP_AND) ? UNIT_AND :
                             (opSel == OP_OR)  ? UNIT_OR  : UNIT_XOR;
          strobes.wrResult = 1'b1;
          strobes.updZero  = 1'b1;
          strobes.updNeg   = 1'b1;
        end
        OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
          strobes.unit     = (opSel == OP_SHL || opSel == OP_ROL) ? UNIT_SHL : UNIT_SHR;
          strobes.rotate   = (opSel == OP_ROL || opSel == OP_ROR);
          strobes.wrResult = 1'b1;
          strobes.updCarry = 1'b1;
          strobes.updZero  = 1'b1;
          strobes.updNeg   = 1'b1;
        end
        OP_INC, OP_DEC: begin
          strobes.unit           = UNIT_ADD;
          strobes.addFromOperand = 1'b1;
          strobes.addB           = (opSel == OP_INC) ? B_ZERO : B_ONES;
          strobes.cin            = (opSel == OP_INC) ? CIN_ONE : CIN_ZERO;
          strobes.wrResult       = 1'b1;
          strobes.updZero        = 1'b1;
          strobes.updNeg         = 1'b1;
        end
        OP_CMP: begin
          strobes.unit     = UNIT_ADD;
          strobes.addB     = B_INVERTED;
          strobes.cin      = CIN_ONE;
          strobes.updCarry = 1'b1;
          strobes.updZero  = 1'b1;
          strobes.updNeg   = 1'b1;
        end
        OP_BIT: begin
          strobes.unit    = UNIT_AND;
          strobes.bitTest = 1'b1;
          strobes.updZero = 1'b1;
          strobes.updNeg  = 1'b1;
          strobes.updOvf  = 1'b1;
        end
        OP_LOAD: begin
          strobes.unit     = UNIT_PASS;
          strobes.wrResult = 1'b1;
          strobes.updZero  = 1'b1;
          strobes.updNeg   = 1'b1;
        end
        default: ;  // unused codes: no strobes
      endcase
    end
  end

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              resultWrEn,
  output logic              carryOut,
  output logic              carryUpd,
  output logic              zeroOut,
  output logic              zeroUpd,
  output logic              negOut,
  output logic              negUpd,
  output logic              ovfOut,
  output logic              ovfUpd
);

  localparam int SIGN_BIT = DATA_W - 1;
  localparam int NEXT_BIT = DATA_W - 2;

  logic [DATA_W-1:0] addA, addB, resNext;
  logic [DATA_W:0]   sum;
  logic              cinBit, shiftIn, addOvf;
  logic              carryNext, zeroNext, negNext, ovfNext;

  // Shared adder: add, subtract, compare, increment, decrement.
  always_comb begin
    addA = strobes.addFromOperand ? operandIn : accIn;
    case (strobes.addB)
      B_INVERTED: addB = ~operandIn;
      B_ZERO:     addB = '0;
      B_ONES:     addB = '1;
      default:    addB = operandIn;
    endcase
    case (strobes.cin)
      CIN_ONE:  cinBit = 1'b1;
      CIN_ZERO: cinBit = 1'b0;
      default:  cinBit = carryIn;
    endcase
    sum    = {1'b0, addA} + {1'b0, addB} + {{DATA_W{1'b0}}, cinBit};
    addOvf = (addA[SIGN_BIT] == addB[SIGN_BIT]) && (sum[SIGN_BIT] != addA[SIGN_BIT]);
  end

  assign shiftIn = strobes.rotate ? carryIn : 1'b0;

  // Result selection and flag formation.
  always_comb begin
    carryNext = carryIn;
    case (strobes.unit)
      UNIT_ADD: begin
        resNext   = sum[DATA_W-1:0];
        carryNext = sum[DATA_W];
      end
      UNIT_AND: resNext = accIn & operandIn;
      UNIT_OR:  resNext = accIn | operandIn;
      UNIT_XOR: resNext = accIn ^ operandIn;
      UNIT_SHL: begin
        resNext   = {accIn[DATA_W-2:0], shiftIn};
        carryNext = accIn[SIGN_BIT];
      end
      UNIT_SHR: begin
        resNext   = {shiftIn, accIn[DATA_W-1:1]};
        carryNext = accIn[0];
      end
      default:  resNext = operandIn;
    endcase
    zeroNext = (resNext == '0);
    negNext  = strobes.bitTest ? operandIn[SIGN_BIT] : resNext[SIGN_BIT];
    ovfNext  = strobes.bitTest ? operandIn[NEXT_BIT] : addOvf;
  end

  // Output registers: enables follow strobes, values load only when enabled.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut  <= '0;
      resultWrEn <= 1'b0;
      carryOut   <= 1'b0;
      carryUpd   <= 1'b0;
      zeroOut    <= 1'b0;
      zeroUpd    <= 1'b0;
      negOut     <= 1'b0;
      negUpd     <= 1'b0;
      ovfOut     <= 1'b0;
      ovfUpd     <= 1'b0;
    end else begin
      resultWrEn <= strobes.wrResult;
      carryUpd   <= strobes.updCarry;
      zeroUpd    <= strobes.updZero;
      negUpd     <= strobes.updNeg;
      ovfUpd     <= strobes.updOvf;
      if (strobes.wrResult) resultOut <= resNext;
      if (strobes.updCarry) carryOut  <= carryNext;
      if (strobes.updZero)  zeroOut   <= zeroNext;
      if (strobes.updNeg)   negOut    <= negNext;
      if (strobes.updOvf)   ovfOut    <= ovfNext;
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              resultWrEn,
  output logic              carryOut,
  output logic              carryUpd,
  output logic              zeroOut,
  output logic              zeroUpd,
  output logic              negOut,
  output logic              negUpd,
  output logic              ovfOut,
  output logic              ovfUpd
);

  ctrlStrobes_t strobes;

  acc_alu_ctrl ctrl_i (
    .opValid (opValid),
    .opSel   (opSel),
    .strobes (strobes)
  );

  acc_alu_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .accIn      (accIn),
    .operandIn  (operandIn),
    .carryIn    (carryIn),
    .resultOut  (resultOut),
    .resultWrEn (resultWrEn),
    .carryOut   (carryOut),
    .carryUpd   (carryUpd),
    .zeroOut    (zeroOut),
    .zeroUpd    (zeroUpd),
    .negOut     (negOut),
    .negUpd     (negUpd),
    .ovfOut     (ovfOut),
    .ovfUpd     (ovfUpd)
  );

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opSel,
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] operandIn,
  input logic              carryIn,
  input logic [DATA_W-1:0] resultOut,
  input logic              resultWrEn,
  input logic              carryUpd,
  input logic              zeroOut,
  input logic              zeroUpd,
  input logic              negOut,
  input logic              negUpd,
  input logic              ovfOut,
  input logic              ovfUpd
);

  logic [DATA_W-1:0] addExp;
  logic [DATA_W-1:0] andVal;
  logic              anyEn;

  assign addExp = accIn + operandIn + {{(DATA_W-1){1'b0}}, carryIn};
  assign andVal = accIn & operandIn;
  assign anyEn  = resultWrEn | carryUpd | zeroUpd | negUpd | ovfUpd;

  assert_add_sum_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 4'd0) |=> resultWrEn && resultOut == $past(addExp));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (resultWrEn && zeroUpd) |-> (zeroOut == (resultOut == '0)));

  assert_incdec_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == 4'd9 || opSel == 4'd10)) |=> resultWrEn && !carryUpd && !ovfUpd);

  assert_cmp_nowrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 4'd11) |=> !resultWrEn && carryUpd && zeroUpd && negUpd && !ovfUpd
                                     && $stable(resultOut));

  assert_bit_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 4'd12) |=> !resultWrEn && !carryUpd
      && negOut == $past(operandIn[DATA_W-1]) && ovfOut == $past(operandIn[DATA_W-2])
      && zeroOut == ($past(andVal) == '0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !anyEn && $stable(resultOut));

  assert_unused_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel >= 4'd14) |=> !anyEn && $stable(resultOut));

endmodule

bind acc_alu acc_alu_checker #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .opSel      (opSel),
  .accIn      (accIn),
  .operandIn  (operandIn),
  .carryIn    (carryIn),
  .resultOut  (resultOut),
  .resultWrEn (resultWrEn),
  .carryUpd   (carryUpd),
  .zeroOut    (zeroOut),
  .zeroUpd    (zeroUpd),
  .negOut     (negOut),
  .negUpd     (negUpd),
  .ovfOut     (ovfOut),
  .ovfUpd     (ovfUpd)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk;
  logic         rstN;
  logic         opValid;
  logic [3:0]   opSel;
  logic [W-1:0] accIn, operandIn;
  logic         carryIn;
  logic [W-1:0] resultOut;
  logic         resultWrEn, carryOut, carryUpd, zeroOut, zeroUpd;
  logic         negOut, negUpd, ovfOut, ovfUpd;

  int checkCount = 0;
  int failCount  = 0;
  int lastResult = 0;

  acc_alu #(.DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .accIn(accIn), .operandIn(operandIn), .carryIn(carryIn),
    .resultOut(resultOut), .resultWrEn(resultWrEn),
    .carryOut(carryOut), .carryUpd(carryUpd),
    .zeroOut(zeroOut), .zeroUpd(zeroUpd),
    .negOut(negOut), .negUpd(negUpd),
    .ovfOut(ovfOut), .ovfUpd(ovfUpd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkVal(string req, string what, int got, int exp);
    checkCount++;
    if (got != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Present one operation at a falling edge; check at the next falling edge.
  task automatic runOp(string req, int op, int a, int b, int c);
    int res, cy, z, n, v, s, bb;
    bit wr, uc, uz, un, uv;
    res = 0; cy = 0; v = 0; wr = 0; uc = 0; uz = 0; un = 0; uv = 0;
    case (op)
      0, 1: begin
        bb  = (op == 1) ? ((~b) & 255) : b;
        s   = a + bb + c;
        res = s & 255;
        cy  = (s >> 8) & 1;
        v   = (((a ^ res) & (bb ^ res)) >> 7) & 1;
        wr = 1; uc = 1; uz = 1; un = 1; uv = 1;
      end
      2: begin res = a & b; wr = 1; uz = 1; un = 1; end
      3: begin res = a | b; wr = 1; uz = 1; un = 1; end
      4: begin res = a ^ b; wr = 1; uz = 1; un = 1; end
      5: begin res = (a << 1) & 255; cy = (a >> 7) & 1; wr = 1; uc = 1; uz = 1; un = 1; end
      6: begin res = a >> 1; cy = a & 1; wr = 1; uc = 1; uz = 1; un = 1; end
      7: begin res = ((a << 1) | c) & 255; cy = (a >> 7) & 1; wr = 1; uc = 1; uz = 1; un = 1; end
      8: begin res = (a >> 1) | (c << 7); cy = a & 1; wr = 1; uc = 1; uz = 1; un = 1; end
      9: begin res = (b + 1) & 255; wr = 1; uz = 1; un = 1; end
      10: begin res = (b + 255) & 255; wr = 1; uz = 1; un = 1; end
      11: begin res = (a - b) & 255; cy = (a >= b) ? 1 : 0; uc = 1; uz = 1; un = 1; end
      12: begin res = a & b; uz = 1; un = 1; uv = 1; end
      13: begin res = b; wr = 1; uz = 1; un = 1; end
      default: ;
    endcase
    z = (res == 0) ? 1 : 0;
    n = (res >> 7) & 1;
    if (op == 12) begin
      n = (b >> 7) & 1;
      v = (b >> 6) & 1;
    end

    opValid   = 1'b1;
    opSel     = 4'(op);
    accIn     = 8'(a);
    operandIn = 8'(b);
    carryIn   = 1'(c);
    @(negedge clk);

    checkVal(req, "resultWrEn", int'(resultWrEn), int'(wr));
    checkVal(req, "carryUpd", int'(carryUpd), int'(uc));
    checkVal(req, "zeroUpd", int'(zeroUpd), int'(uz));
    checkVal(req, "negUpd", int'(negUpd), int'(un));
    checkVal(req, "ovfUpd", int'(ovfUpd), int'(uv));
    if (wr) lastResult = res;
    checkVal(req, wr ? "result" : "result held", int'(resultOut), lastResult);
    if (uc) checkVal(req, "carry", int'(carryOut), cy);
    if (uz) checkVal(req, "zero", int'(zeroOut), z);
    if (un) checkVal(req, "negative", int'(negOut), n);
    if (uv) checkVal(req, "overflow", int'(ovfOut), v);
  endtask

  task automatic testReset();
    opValid = 1'b0; opSel = '0; accIn = '0; operandIn = '0; carryIn = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R1", "result in reset", int'(resultOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", "result", int'(resultOut), 0);
    checkVal("R1", "enables", int'({resultWrEn, carryUpd, zeroUpd, negUpd, ovfUpd}), 0);
    checkVal("R1", "flags", int'({carryOut, zeroOut, negOut, ovfOut}), 0);
  endtask

  task automatic testAddSub();
    runOp("R2", 0, 8'h10, 8'h20, 0);
    runOp("R2", 0, 8'hFF, 8'h01, 0);   // carry out, zero result
    runOp("R2", 0, 8'h3F, 8'h40, 1);   // carry in, signed overflow
    runOp("R3", 0, 8'h50, 8'h50, 0);   // positive + positive -> negative
    runOp("R3", 0, 8'h80, 8'h80, 0);   // negative + negative -> positive
    runOp("R2", 1, 8'h50, 8'h30, 1);   // no borrow
    runOp("R2", 1, 8'h00, 8'h01, 1);   // borrow, wraps to 0xFF
    runOp("R2", 1, 8'h50, 8'h30, 0);   // borrow in
    runOp("R3", 1, 8'h50, 8'hB0, 1);   // positive - negative overflows
  endtask

  task automatic testLogic();
    runOp("R4", 2, 8'hF0, 8'h3C, 1);
    runOp("R4", 2, 8'h0F, 8'hF0, 0);   // zero result
    runOp("R4", 3, 8'h80, 8'h01, 0);
    runOp("R4", 4, 8'hAA, 8'hAA, 1);   // zero result
    runOp("R4", 4, 8'h55, 8'hFF, 0);
  endtask

  task automatic testShift();
    runOp("R5", 5, 8'h81, 8'h00, 1);   // carry in ignored
    runOp("R5", 5, 8'h40, 8'h00, 0);
    runOp("R5", 6, 8'h01, 8'h00, 1);   // result zero, carry set
    runOp("R5", 6, 8'hFE, 8'h00, 0);
  endtask

  task automatic testRotate();
    runOp("R6", 7, 8'h80, 8'h00, 1);
    runOp("R6", 7, 8'h80, 8'h00, 0);   // zero result
    runOp("R6", 8, 8'h01, 8'h00, 1);
    runOp("R6", 8, 8'h02, 8'h00, 0);
  endtask

  task automatic testIncDec();
    runOp("R7", 9, 8'h33, 8'hFF, 1);   // wraps to 0
    runOp("R7", 9, 8'h00, 8'h7F, 0);   // becomes negative
    runOp("R7", 10, 8'h00, 8'h00, 1);  // wraps to 0xFF
    runOp("R7", 10, 8'hFF, 8'h01, 0);  // zero from own result
  endtask

  task automatic testCompare();
    runOp("R8", 11, 8'h40, 8'h20, 0);
    runOp("R8", 11, 8'h40, 8'h40, 0);
    runOp("R8", 11, 8'h20, 8'h40, 1);
    runOp("R8", 11, 8'h00, 8'hFF, 1);
  endtask

  task automatic testBitTest();
    runOp("R9", 12, 8'h0F, 8'hC0, 1);
    runOp("R9", 12, 8'hFF, 8'h01, 0);
    runOp("R9", 12, 8'h40, 8'h40, 0);
  endtask

  task automatic testLoad();
    runOp("R10", 13, 8'h12, 8'h00, 1);
    runOp("R10", 13, 8'h00, 8'h80, 0);
    runOp("R10", 13, 8'h00, 8'h5A, 0);
  endtask

  task automatic testIdle();
    runOp("R11", 13, 8'h00, 8'h6B, 0);
    opValid = 1'b0; opSel = 4'd13; accIn = 8'hAA; operandIn = 8'h00; carryIn = 1'b1;
    @(negedge clk);
    checkVal("R11", "idle enables", int'({resultWrEn, carryUpd, zeroUpd, negUpd, ovfUpd}), 0);
    checkVal("R11", "idle result held", int'(resultOut), lastResult);
    @(negedge clk);
    checkVal("R11", "idle result held 2", int'(resultOut), lastResult);
  endtask

  task automatic testUnused();
    runOp("R12", 14, 8'h11, 8'h22, 1);
    runOp("R12", 15, 8'hFF, 8'hFF, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog R11: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    @(negedge clk);
    testReset();
    testAddSub();
    testLogic();
    testShift();
    testRotate();
    testIncDec();
    testCompare();
    testBitTest();
    testLoad();
    testIdle();
    testUnused();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule